// File: doc/BRIEF.md
# Fine-Grained Multithread Issue Selector

This block sits in front of a shared in-order pipeline and chooses, every cycle, which of four hardware threads may issue its next instruction. Each thread reports a set of level conditions: whether an instruction is waiting, whether a cache miss is outstanding, whether a trap or interrupt is pending, whether a resource conflict blocks it, and whether the waiting instruction is a load. The selector combines these with its own per-thread load hold-off counters to decide which threads are eligible. Among the eligible threads it grants the one that was scheduled least recently.

The grant is combinational from the current inputs and the stored state. Consecutive cycles can grant different threads, so switching threads costs no idle slot. The stored state consists of an age ordering of the threads and one small down-counter per thread. Both update on the rising clock edge. Reset is synchronous and active high.

Top module: `mt_issue_sel`

## Requirements
- R1: At most one bit of `grant` is set. `grant_vld` is high exactly when a bit of `grant` is set, and `grant_id` then holds the index of that bit.
- R2: A thread is eligible only when its `inst_rdy` bit is 1, its `miss_pend`, `trap_pend` and `res_busy` bits are all 0, and its hold-off counter is zero. A thread that is not eligible is never granted.
- R3: Among the eligible threads, the grant goes to the one earliest in the age order, which is the least recently granted thread.
- R4: On each grant, the granted thread moves to the newest place in the age order. The other threads keep their relative order.
- R5: When no thread is eligible, `grant_vld` is 0, `grant` is all zeros, and the age order is left unchanged.
- R6: When a thread is granted with its `inst_is_ld` bit set to 1, that thread is not granted in the next two cycles. It becomes eligible again in the third cycle. Other threads may be granted during the two blocked cycles.
- R7: The grant may move to a different thread on every cycle, with no idle cycle between the two grants.
- R8: While `rst` is high at a rising edge, the age order is set to thread 0 oldest, then 1, then 2, with thread 3 newest, and all hold-off counters are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inst_rdy | input | 4 | Per thread: an instruction is available to issue |
| miss_pend | input | 4 | Per thread: a cache miss is outstanding |
| trap_pend | input | 4 | Per thread: a trap or interrupt is pending |
| res_busy | input | 4 | Per thread: a resource conflict blocks issue |
| inst_is_ld | input | 4 | Per thread: the waiting instruction is a load |
| grant | output | 4 | One-hot grant, bit i for thread i |
| grant_id | output | 2 | Index of the granted thread |
| grant_vld | output | 1 | A thread is granted this cycle |

## Verification
The bench issues a load and then probes the same thread one and two cycles later, and again in the third cycle. A counter that is off by one would either release the thread too early or hold it one cycle too long. Several sequences grant threads out of index order, so an age update that reorders the surviving threads, or a selector that simply picks the lowest index, gives the wrong winner. The bench also applies idle cycles and then checks that the age order is unchanged: a design that moves a thread on a cycle with no grant would pick the wrong thread afterwards. A reset in the middle of a run must restore thread 0 as oldest and clear a live hold-off. A design that missed either would refuse the held thread or favour the wrong one.

// File: rtl/mts_pkg.sv
package mts_pkg;

    localparam int unsigned THREADS  = 4;
    localparam int unsigned LOAD_GAP = 2;

    typedef struct packed {
        logic rdy;
        logic miss;
        logic trap;
        logic busy;
        logic is_ld;
    } thr_cond_t;

    function automatic logic cond_ok(input thr_cond_t c);
        return c.rdy && !c.miss && !c.trap && !c.busy;
    endfunction

endpackage

// File: rtl/mts_holdoff.sv
module mts_holdoff #(
    parameter int unsigned NTHR = mts_pkg::THREADS,
    parameter int unsigned GAP  = mts_pkg::LOAD_GAP
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NTHR-1:0] ld_grant,
    output logic [NTHR-1:0] clear
);
    localparam int unsigned CW = $clog2(GAP + 1);

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        logic [CW-1:0] cnt;
        always_ff @(posedge clk) begin
            if (rst)
                cnt <= '0;
            else if (ld_grant[t])
                cnt <= CW'(GAP);
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
        assign clear[t] = (cnt == '0);
    end
endmodule

// File: rtl/mts_pick.sv
module mts_pick #(
    parameter int unsigned NTHR = mts_pkg::THREADS,
    localparam int unsigned TW  = $clog2(NTHR)
) (
    input  logic [NTHR-1:0] elig,
    input  logic [TW-1:0]   ord [NTHR],
    output logic            found,
    output logic [TW-1:0]   pos,
    output logic [TW-1:0]   tid
);
    always_comb begin
        found = 1'b0;
        pos   = '0;
        tid   = '0;
        for (int k = 0; k < NTHR; k++) begin
            if (!found && elig[ord[k]]) begin
                found = 1'b1;
                pos   = TW'(k);
                tid   = ord[k];
            end
        end
    end
endmodule

// File: rtl/mts_age_order.sv
module mts_age_order #(
    parameter int unsigned NTHR = mts_pkg::THREADS,
    localparam int unsigned TW  = $clog2(NTHR)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd,
    input  logic [TW-1:0] upd_pos,
    input  logic [TW-1:0] upd_tid,
    output logic [TW-1:0] ord [NTHR]
);
    logic [TW-1:0] nxt [NTHR];

    for (genvar k = 0; k < NTHR; k++) begin : g_slot
        if (k == NTHR - 1) begin : g_last
            always_comb nxt[k] = upd ? upd_tid : ord[k];
        end else begin : g_mid
            always_comb begin
                if (upd && (TW'(k) >= upd_pos))
                    nxt[k] = ord[k+1];
                else
                    nxt[k] = ord[k];
            end
        end

        always_ff @(posedge clk) begin
            if (rst)
                ord[k] <= TW'(k);
            else
                ord[k] <= nxt[k];
        end
    end
endmodule

// File: rtl/mt_issue_sel.sv
module mt_issue_sel #(
    parameter int unsigned NTHR = mts_pkg::THREADS,
    parameter int unsigned GAP  = mts_pkg::LOAD_GAP,
    localparam int unsigned TW  = $clog2(NTHR)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NTHR-1:0] inst_rdy,
    input  logic [NTHR-1:0] miss_pend,
    input  logic [NTHR-1:0] trap_pend,
    input  logic [NTHR-1:0] res_busy,
    input  logic [NTHR-1:0] inst_is_ld,
    output logic [NTHR-1:0] grant,
    output logic [TW-1:0]   grant_id,
    output logic            grant_vld
);
    import mts_pkg::*;

    thr_cond_t [NTHR-1:0] cond;
    logic [NTHR-1:0] hold_clr;
    logic [NTHR-1:0] elig;
    logic [NTHR-1:0] ld_grant;
    logic [TW-1:0]   ord [NTHR];
    logic            found;
    logic [TW-1:0]   win_pos;
    logic [TW-1:0]   win_tid;

    for (genvar t = 0; t < NTHR; t++) begin : g_cond
        assign cond[t]     = '{rdy: inst_rdy[t], miss: miss_pend[t], trap: trap_pend[t],
                               busy: res_busy[t], is_ld: inst_is_ld[t]};
        assign elig[t]     = cond_ok(cond[t]) && hold_clr[t];
        assign grant[t]    = found && (win_tid == TW'(t));
        assign ld_grant[t] = grant[t] && cond[t].is_ld;
    end

    mts_holdoff #(.NTHR(NTHR), .GAP(GAP)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .ld_grant (ld_grant),
        .clear    (hold_clr)
    );

    mts_pick #(.NTHR(NTHR)) u_pick (
        .elig  (elig),
        .ord   (ord),
        .found (found),
        .pos   (win_pos),
        .tid   (win_tid)
    );

    mts_age_order #(.NTHR(NTHR)) u_age (
        .clk     (clk),
        .rst     (rst),
        .upd     (found),
        .upd_pos (win_pos),
        .upd_tid (win_tid),
        .ord     (ord)
    );

    assign grant_vld = found;
    assign grant_id  = win_tid;
endmodule

// File: rtl/mts_checker.sv
module mts_checker #(
    parameter int unsigned NTHR = 4,
    localparam int unsigned TW  = $clog2(NTHR)
) (
    input logic            clk,
    input logic            rst,
    input logic [NTHR-1:0] inst_rdy,
    input logic [NTHR-1:0] miss_pend,
    input logic [NTHR-1:0] trap_pend,
    input logic [NTHR-1:0] res_busy,
    input logic [NTHR-1:0] inst_is_ld,
    input logic [NTHR-1:0] grant,
    input logic [TW-1:0]   grant_id,
    input logic            grant_vld
);
    logic [NTHR-1:0] cond_ok;
    assign cond_ok = inst_rdy & ~miss_pend & ~trap_pend & ~res_busy;

    p_onehot_r1: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));
    p_vld_r1:    assert property (@(posedge clk) disable iff (rst) grant_vld == (grant != '0));
    p_id_r1:     assert property (@(posedge clk) disable iff (rst) grant_vld |-> grant[grant_id]);
    p_idle_r5:   assert property (@(posedge clk) disable iff (rst)
                                  (cond_ok == '0) |-> (!grant_vld && grant == '0));

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        p_elig_r2:  assert property (@(posedge clk) disable iff (rst)
                                     grant[t] |-> cond_ok[t]);
        p_hold1_r6: assert property (@(posedge clk) disable iff (rst)
                                     (grant[t] && inst_is_ld[t]) |=> !grant[t]);
        p_hold2_r6: assert property (@(posedge clk) disable iff (rst)
                                     (grant[t] && inst_is_ld[t]) |=> ##1 !grant[t]);
    end
endmodule

bind mt_issue_sel mts_checker #(.NTHR(NTHR)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .inst_rdy   (inst_rdy),
    .miss_pend  (miss_pend),
    .trap_pend  (trap_pend),
    .res_busy   (res_busy),
    .inst_is_ld (inst_is_ld),
    .grant      (grant),
    .grant_id   (grant_id),
    .grant_vld  (grant_vld)
);

// File: tb/sim_mt_issue_sel.sv
module sim_mt_issue_sel;
    logic clk = 1'b0;
    logic rst;
    logic [3:0] inst_rdy, miss_pend, trap_pend, res_busy, inst_is_ld;
    logic [3:0] grant;
    logic [1:0] grant_id;
    logic       grant_vld;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    mt_issue_sel u0 (
        .clk(clk), .rst(rst), .inst_rdy(inst_rdy), .miss_pend(miss_pend),
        .trap_pend(trap_pend), .res_busy(res_busy), .inst_is_ld(inst_is_ld),
        .grant(grant), .grant_id(grant_id), .grant_vld(grant_vld)
    );

    // {rdy, miss, trap, busy, load, expected grant}; walked from reset
    localparam int NV = 17;
    localparam logic [23:0] VEC [NV] = '{
        {4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 4'b0001},  // 0  R3 thread0 oldest
        {4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 4'b0010},  // 1  R7 switch, no bubble
        {4'hF, 4'h0, 4'h0, 4'h0, 4'b0100, 4'b0100}, // 2 R6 load on thread2
        {4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 4'b1000},  // 3  R6 others still issue
        {4'b0100, 4'h0, 4'h0, 4'h0, 4'h0, 4'b0000}, // 4 R6 second blocked cycle
        {4'b0100, 4'h0, 4'h0, 4'h0, 4'h0, 4'b0100}, // 5 R6 released third cycle
        {4'hF, 4'b0001, 4'h0, 4'h0, 4'h0, 4'b0010}, // 6 R2 miss blocks 0
        {4'hF, 4'h0, 4'b0001, 4'b1000, 4'h0, 4'b0100}, // 7 R4 trap/busy block
        {4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 4'b0001},  // 8  R3
        {4'b0011, 4'h0, 4'h0, 4'h0, 4'h0, 4'b0010}, // 9 R4 order after moves
        {4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'b0000},  // 10 R5 idle
        {4'hF, 4'h0, 4'h0, 4'h0, 4'hF, 4'b1000},  // 11 R5 order kept over idle
        {4'b1000, 4'h0, 4'h0, 4'h0, 4'h0, 4'b0000}, // 12 R6 held
        {4'b1001, 4'h0, 4'h0, 4'h0, 4'b1001, 4'b0001}, // 13 R6 held, other wins
        {4'b1001, 4'h0, 4'h0, 4'h0, 4'h0, 4'b1000}, // 14 R6 released
        {4'b1001, 4'h0, 4'h0, 4'h0, 4'h0, 4'b1000}, // 15 R6 thread0 still held
        {4'b1001, 4'h0, 4'h0, 4'h0, 4'h0, 4'b0001}  // 16 R3 thread0 now oldest
    };

    function automatic string tag_of(input int i);
        case (i)
            1:                     return "R7";
            2, 3, 4, 5, 12, 13, 14, 15: return "R6";
            6:                     return "R2";
            7, 9:                  return "R4";
            10, 11:                return "R5";
            default:               return "R3";
        endcase
    endfunction

    task automatic check(input string req, input logic [3:0] exp_g);
        logic [1:0] exp_id = 2'd0;
        logic       exp_v  = (exp_g != 4'h0);
        for (int b = 0; b < 4; b++) if (exp_g[b]) exp_id = 2'(b);
        n_chk++;
        if (grant !== exp_g || grant_vld !== exp_v || (exp_v && grant_id !== exp_id)) begin
            n_fail++;
            $display("FAIL %s: grant=%b vld=%b id=%0d, expected grant=%b vld=%b id=%0d",
                     req, grant, grant_vld, grant_id, exp_g, exp_v, exp_id);
        end
    endtask

    task automatic drive(input logic [3:0] r, input logic [3:0] m, input logic [3:0] t,
                         input logic [3:0] b, input logic [3:0] l);
        inst_rdy = r; miss_pend = m; trap_pend = t; res_busy = b; inst_is_ld = l;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        drive(4'h0, 4'h0, 4'h0, 4'h0, 4'h0);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        drive(4'h0, 4'h0, 4'h0, 4'h0, 4'h0);
        do_reset();

        // Reset state: nothing available, no grant (R5); then thread0 oldest (R8)
        #1 check("R5", 4'b0000);
        @(negedge clk);
        drive(4'h0, 4'h0, 4'h0, 4'h0, 4'h0);
        #1 check("R8", 4'b0000);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][23:20], VEC[i][19:16], VEC[i][15:12], VEC[i][11:8], VEC[i][7:4]);
            #1 check(tag_of(i), VEC[i][3:0]);
        end

        // R8: reset restores order and clears a live hold-off
        do_reset();
        @(negedge clk);
        drive(4'hF, 4'h0, 4'h0, 4'h0, 4'h0);
        #1 check("R8", 4'b0001);                 // thread0 oldest after reset
        @(negedge clk);
        drive(4'b0010, 4'h0, 4'h0, 4'h0, 4'b0010);
        #1 check("R6", 4'b0010);                 // load on thread1
        @(negedge clk);
        drive(4'b0010, 4'h0, 4'h0, 4'h0, 4'h0);
        #1 check("R6", 4'b0000);                 // held
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        drive(4'b1010, 4'h0, 4'h0, 4'h0, 4'h0);
        #1 check("R8", 4'b0010);                 // hold cleared, 1 older than 3
        @(negedge clk);
        drive(4'b1010, 4'h0, 4'h0, 4'h0, 4'h0);
        #1 check("R7", 4'b1000);                 // back-to-back switch

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule